// File: doc/BRIEF.md
# Accelerator Job Command Sequencer

This block is the accelerator-side job controller for a coherent host-attach link. On that link the host-side service unit is the only bus master. The accelerator can only ask for work through tagged commands, and it must match every returned data write and every completion back to a tag it still has open. A job-control port carries two requests. One resets the block to a known, ready state. The other starts a job and supplies the address of a work-element descriptor, which the block latches as its job context.

After a start, the block requests the descriptor with one cache-line read command that asks the service unit to keep the line cached. The command takes a tag from an eight-entry pool and is sent only when the command port holds a credit. The 128-byte line comes back as four 32-byte buffer writes, each marked with the tag and a beat offset. The job runs only after a clean completion arrives for that tag. A failed completion, or a completion that arrives before all four beats, ends the job with an error pulse and sends the block back to ready.

A reset request abandons a fetch that is in flight. Its tag stays reserved until the late completion arrives, so the tag is never reused while the service unit may still write to it.

Top module: `job_cmd_sequencer`

## Requirements
- R1: While rstN is low and afterwards, jobReady stays 0 until a reset request is seen (jobValid=1, jobOp=1). jobReady is 1 from the clock edge that samples that request.
- R2: A start request (jobValid=1, jobOp=2) sampled while ready latches jobAddr. Two edges later cmdValid pulses for one cycle with cmdCode=16'h0A60 and cmdAddr equal to the latched address.
- R3: A start request is ignored before the first reset request and while a job is running: no command is issued.
- R4: Each command takes the lowest-numbered tag that has no completion pending. A tag stays in use until a completion (rspValid) with that tag is received.
- R5: The command port starts with CREDITS credits. Each command uses one credit, and each one-cycle cmdCredit pulse returns one. No command is issued while the count is zero.
- R6: A buffer write with the job's tag and beat offset k (0..3) places bufWrData at descData bits [256*k +: 256].
- R7: jobRunning rises only after a completion with the job's tag and rspCode=0 that arrives after all four beats have been written.
- R8: A completion with the job's tag and a non-zero rspCode, or one that arrives before all four beats, pulses jobFail for one cycle. jobReady is 1 in that same cycle, and jobRunning stays 0.
- R9: A buffer write or completion whose tag is not pending pulses tagErr in the next cycle and changes neither descData nor the job state.
- R10: A reset request in any state returns the block to ready. A completion that arrives later for an abandoned tag frees that tag without raising tagErr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| jobValid | input | 1 | Job-control request strobe |
| jobOp | input | 2 | Request kind: 1 = reset, 2 = start |
| jobAddr | input | ADDR_W | Descriptor address carried by a start request |
| jobReady | output | 1 | Idle and able to accept a start |
| jobRunning | output | 1 | Descriptor loaded; job running |
| jobFail | output | 1 | One-cycle pulse: job ended with an error |
| cmdValid | output | 1 | Command issued this cycle |
| cmdCode | output | 16 | Command code (cache-line read with caching) |
| cmdTag | output | log2(TAGS) | Tag of the issued command |
| cmdAddr | output | ADDR_W | Address of the issued command |
| cmdCredit | input | 1 | One-cycle pulse returning one command credit |
| bufWrValid | input | 1 | Buffer write from the service unit |
| bufWrTag | input | log2(TAGS) | Tag of the buffer write |
| bufWrBeat | input | 2 | Beat offset within the line |
| bufWrData | input | 256 | Beat data |
| rspValid | input | 1 | Completion strobe |
| rspTag | input | log2(TAGS) | Tag being completed |
| rspCode | input | 8 | Completion code, 0 = success |
| tagErr | output | 1 | One-cycle pulse: write or completion for a tag that is not pending |
| descData | output | 1024 | Descriptor line as assembled |

## Verification
The descriptor fetch is run on random addresses, with random data and the four beats delivered in a random order. This shows that each beat is placed by its offset and not by its arrival order. Directed sequences then separate the ways a job can end: a clean completion, an error code, a completion that arrives too early, and a reset part-way through a fetch. The reset case makes the next command take a different tag, and its late completion must be accepted silently. Holding back credits shows that issue stalls on the credit count and not on the tag pool. Writes and completions with unknown tags confirm that they only flag an error and leave descData as it was.

// File: rtl/jcs_pkg.sv
package jcs_pkg;
  localparam int DESC_BEATS = 4;
  localparam int BEAT_IDX_W = $clog2(DESC_BEATS);
  localparam logic [15:0] CMD_RD_CL_CACHED = 16'h0A60;
  localparam logic [1:0] OP_RESET = 2'd1;
  localparam logic [1:0] OP_START = 2'd2;

  typedef enum logic [2:0] {
    ST_UNINIT, ST_IDLE, ST_ISSUE, ST_WAIT, ST_RUN
  } seqState_t;

  typedef struct packed {
    logic latchAddr;
    logic clearBeats;
    logic wrEn;
    logic [BEAT_IDX_W-1:0] wrBeat;
  } dpStrobe_t;
endpackage

// File: rtl/jcs_ctrl.sv
module jcs_ctrl
  import jcs_pkg::*;
#(
  parameter int TAGS    = 8,
  parameter int CREDITS = 4,
  localparam int TAG_W  = $clog2(TAGS),
  localparam int CR_W   = $clog2(CREDITS + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  jobValid,
  input  logic [1:0]            jobOp,
  input  logic                  bufWrValid,
  input  logic [TAG_W-1:0]      bufWrTag,
  input  logic [BEAT_IDX_W-1:0] bufWrBeat,
  input  logic                  rspValid,
  input  logic [TAG_W-1:0]      rspTag,
  input  logic [7:0]            rspCode,
  input  logic                  cmdCredit,
  input  logic                  allBeats,
  output dpStrobe_t             strobe,
  output logic                  jobReady,
  output logic                  jobRunning,
  output logic                  jobFail,
  output logic                  cmdValid,
  output logic [TAG_W-1:0]      cmdTag,
  output logic                  tagErr
);
  seqState_t state;
  logic [TAGS-1:0] busy;
  logic [CR_W-1:0] credit;
  logic [TAG_W-1:0] curTag, freeTag;
  logic freeAvail, resetNow, startNow, issueNow, wrHit, rspHit, badTag;

  always_comb begin
    freeTag   = '0;
    freeAvail = 1'b0;
    for (int i = TAGS - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        freeTag   = TAG_W'(i);
        freeAvail = 1'b1;
      end
    end
  end

  assign resetNow = jobValid && jobOp == OP_RESET;
  assign startNow = state == ST_IDLE && jobValid && jobOp == OP_START;
  assign issueNow = state == ST_ISSUE && !resetNow && credit != '0 && freeAvail;
  assign wrHit    = bufWrValid && state == ST_WAIT && bufWrTag == curTag;
  assign rspHit   = rspValid && state == ST_WAIT && rspTag == curTag;
  assign badTag   = (bufWrValid && !busy[bufWrTag]) || (rspValid && !busy[rspTag]);

  assign strobe.latchAddr  = startNow;
  assign strobe.clearBeats = startNow;
  assign strobe.wrEn       = wrHit;
  assign strobe.wrBeat     = bufWrBeat;

  assign jobReady   = state == ST_IDLE;
  assign jobRunning = state == ST_RUN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= '0;
      credit <= CR_W'(CREDITS);
    end else begin
      logic [TAGS-1:0] busyN;
      logic [CR_W-1:0] creditN;
      busyN = busy;
      if (rspValid) busyN[rspTag] = 1'b0;
      if (issueNow) busyN[freeTag] = 1'b1;
      creditN = credit;
      if (issueNow) creditN = creditN - 1'b1;
      if (cmdCredit && creditN < CR_W'(CREDITS)) creditN = creditN + 1'b1;
      busy   <= busyN;
      credit <= creditN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_UNINIT;
      curTag   <= '0;
      cmdValid <= 1'b0;
      cmdTag   <= '0;
      jobFail  <= 1'b0;
      tagErr   <= 1'b0;
    end else begin
      cmdValid <= issueNow;
      jobFail  <= 1'b0;
      tagErr   <= badTag;
      if (issueNow) begin
        cmdTag <= freeTag;
        curTag <= freeTag;
      end
      if (resetNow) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE:  if (startNow) state <= ST_ISSUE;
          ST_ISSUE: if (issueNow) state <= ST_WAIT;
          ST_WAIT: begin
            if (rspHit) begin
              if (rspCode == 8'd0 && allBeats) begin
                state <= ST_RUN;
              end else begin
                state   <= ST_IDLE;
                jobFail <= 1'b1;
              end
            end
          end
          default: state <= state;
        endcase
      end
    end
  end

  // R5
  no_cmd_without_credit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (credit == '0) |=> !cmdValid);
  // R4
  tag_not_reused_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (($past(busy) & (TAGS'(1) << cmdTag)) == '0));
  // R9
  tag_err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    tagErr |-> $past(bufWrValid || rspValid));
  // R8
  fail_to_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    jobFail |-> (jobReady && !jobRunning));
  // R7
  running_has_beats_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(jobRunning) |-> allBeats);
endmodule

// File: rtl/jcs_dpath.sv
module jcs_dpath
  import jcs_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int BEAT_W = 256,
  localparam int LINE_W = BEAT_W * DESC_BEATS
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] jobAddr,
  input  logic [BEAT_W-1:0] bufWrData,
  output logic [ADDR_W-1:0] ctxAddr,
  output logic [LINE_W-1:0] descData,
  output logic              allBeats
);
  logic [DESC_BEATS-1:0] beatSeen;

  always_ff @(posedge clk) begin
    if (!rstN) ctxAddr <= '0;
    else if (strobe.latchAddr) ctxAddr <= jobAddr;
  end

  for (genvar b = 0; b < DESC_BEATS; b++) begin : g_beat
    always_ff @(posedge clk) begin
      if (!rstN) begin
        beatSeen[b] <= 1'b0;
        descData[b*BEAT_W +: BEAT_W] <= '0;
      end else if (strobe.clearBeats) begin
        beatSeen[b] <= 1'b0;
      end else if (strobe.wrEn && strobe.wrBeat == BEAT_IDX_W'(b)) begin
        beatSeen[b] <= 1'b1;
        descData[b*BEAT_W +: BEAT_W] <= bufWrData;
      end
    end
  end

  assign allBeats = &beatSeen;

  // R6
  beats_clear_on_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearBeats |=> (beatSeen == '0));
endmodule

// File: rtl/job_cmd_sequencer.sv
module job_cmd_sequencer
  import jcs_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int TAGS    = 8,
  parameter int CREDITS = 4,
  parameter int BEAT_W  = 256,
  localparam int TAG_W  = $clog2(TAGS),
  localparam int LINE_W = BEAT_W * DESC_BEATS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  jobValid,
  input  logic [1:0]            jobOp,
  input  logic [ADDR_W-1:0]     jobAddr,
  output logic                  jobReady,
  output logic                  jobRunning,
  output logic                  jobFail,
  output logic                  cmdValid,
  output logic [15:0]           cmdCode,
  output logic [TAG_W-1:0]      cmdTag,
  output logic [ADDR_W-1:0]     cmdAddr,
  input  logic                  cmdCredit,
  input  logic                  bufWrValid,
  input  logic [TAG_W-1:0]      bufWrTag,
  input  logic [BEAT_IDX_W-1:0] bufWrBeat,
  input  logic [BEAT_W-1:0]     bufWrData,
  input  logic                  rspValid,
  input  logic [TAG_W-1:0]      rspTag,
  input  logic [7:0]            rspCode,
  output logic                  tagErr,
  output logic [LINE_W-1:0]     descData
);
  dpStrobe_t strobe;
  logic allBeats;

  assign cmdCode = CMD_RD_CL_CACHED;

  jcs_ctrl #(.TAGS(TAGS), .CREDITS(CREDITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .jobValid(jobValid), .jobOp(jobOp),
    .bufWrValid(bufWrValid), .bufWrTag(bufWrTag), .bufWrBeat(bufWrBeat),
    .rspValid(rspValid), .rspTag(rspTag), .rspCode(rspCode),
    .cmdCredit(cmdCredit), .allBeats(allBeats), .strobe(strobe),
    .jobReady(jobReady), .jobRunning(jobRunning), .jobFail(jobFail),
    .cmdValid(cmdValid), .cmdTag(cmdTag), .tagErr(tagErr)
  );

  jcs_dpath #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .jobAddr(jobAddr),
    .bufWrData(bufWrData), .ctxAddr(cmdAddr), .descData(descData),
    .allBeats(allBeats)
  );

  // R1
  ready_run_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(jobReady && jobRunning));
endmodule

// File: tb/job_cmd_sequencer_tb.sv
module job_cmd_sequencer_tb;
  localparam int TAGS = 8;
  localparam int CREDITS = 4;

  logic clk = 0, rstN = 0;
  logic jobValid = 0; logic [1:0] jobOp = 0; logic [63:0] jobAddr = 0;
  logic jobReady, jobRunning, jobFail, cmdValid, tagErr;
  logic [15:0] cmdCode; logic [2:0] cmdTag; logic [63:0] cmdAddr;
  logic cmdCredit = 0, bufWrValid = 0, rspValid = 0;
  logic [2:0] bufWrTag = 0, rspTag = 0; logic [1:0] bufWrBeat = 0;
  logic [255:0] bufWrData = 0; logic [7:0] rspCode = 0;
  logic [1023:0] descData;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [TAGS-1:0] mBusy = '0;
  int mCredit = CREDITS;
  logic [255:0] expBeat [4];

  always #2 clk = ~clk;

  job_cmd_sequencer u_dut (
    .clk(clk), .rstN(rstN), .jobValid(jobValid), .jobOp(jobOp), .jobAddr(jobAddr),
    .jobReady(jobReady), .jobRunning(jobRunning), .jobFail(jobFail),
    .cmdValid(cmdValid), .cmdCode(cmdCode), .cmdTag(cmdTag), .cmdAddr(cmdAddr),
    .cmdCredit(cmdCredit), .bufWrValid(bufWrValid), .bufWrTag(bufWrTag),
    .bufWrBeat(bufWrBeat), .bufWrData(bufWrData), .rspValid(rspValid),
    .rspTag(rspTag), .rspCode(rspCode), .tagErr(tagErr), .descData(descData)
  );

  function automatic int lowestFree(logic [TAGS-1:0] b);
    for (int i = 0; i < TAGS; i++) if (!b[i]) return i;
    return -1;
  endfunction

  task automatic check(bit ok, string req, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic jobReq(logic [1:0] op, logic [63:0] a);
    jobValid = 1; jobOp = op; jobAddr = a;
    @(negedge clk); jobValid = 0; jobOp = 0;
  endtask

  task automatic creditBack();
    cmdCredit = 1; @(negedge clk); cmdCredit = 0;
    if (mCredit < CREDITS) mCredit++;
  endtask

  task automatic beat(logic [2:0] t, logic [1:0] k, logic [255:0] d);
    bufWrValid = 1; bufWrTag = t; bufWrBeat = k; bufWrData = d;
    @(negedge clk); bufWrValid = 0;
  endtask

  task automatic rsp(logic [2:0] t, logic [7:0] c);
    rspValid = 1; rspTag = t; rspCode = c;
    @(negedge clk); rspValid = 0;
    mBusy[t] = 1'b0;
  endtask

  // waits for a command; checks tag, code and address against the model
  task automatic expectCmd(logic [63:0] a, output logic [2:0] tg);
    int n = 0;
    while (!cmdValid && n < 20) begin @(negedge clk); n++; end
    check(cmdValid, "R2 cmdValid", 256'(cmdValid), 256'(1));
    check(cmdCode == 16'h0A60, "R2 cmdCode", 256'(cmdCode), 256'h0A60);
    check(cmdAddr == a, "R2 cmdAddr", 256'(cmdAddr), 256'(a));
    check(int'(cmdTag) == lowestFree(mBusy), "R4 tag", 256'(cmdTag), 256'(lowestFree(mBusy)));
    tg = cmdTag;
    mBusy[cmdTag] = 1'b1;
    mCredit--;
    @(negedge clk);
  endtask

  task automatic noCmd(int cycles, string req);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin @(negedge clk); if (cmdValid) seen++; end
    check(seen == 0, req, 256'(seen), 256'(0));
  endtask

  task automatic sendAllBeats(logic [2:0] t);
    int ord [4] = '{0, 1, 2, 3};
    for (int i = 3; i > 0; i--) begin
      int j = $urandom_range(i, 0); int tmp = ord[i]; ord[i] = ord[j]; ord[j] = tmp;
    end
    for (int i = 0; i < 4; i++) begin
      expBeat[ord[i]] = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      beat(t, 2'(ord[i]), expBeat[ord[i]]);
    end
  endtask

  task automatic checkDesc(string req);
    for (int k = 0; k < 4; k++)
      check(descData[k*256 +: 256] == expBeat[k], req, descData[k*256 +: 256], expBeat[k]);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0] t, t0;
    logic [63:0] a;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    check(jobReady == 0, "R1 reset state", 256'(jobReady), 256'(0));
    check(cmdValid == 0 && tagErr == 0 && jobRunning == 0, "R1 outputs low", 256'(cmdValid), 256'(0));
    rstN = 1; @(negedge clk);
    jobReq(2'd2, 64'h1000);
    noCmd(5, "R3 start before reset request");
    check(jobReady == 0, "R1 not ready before reset request", 256'(jobReady), 256'(0));
    jobReq(2'd1, 0);
    check(jobReady == 1, "R1 ready after reset request", 256'(jobReady), 256'(1));

    // random clean jobs
    for (int n = 0; n < 6; n++) begin
      a = {$urandom, $urandom[31:7], 7'b0};
      jobReq(2'd2, a);
      expectCmd(a, t);
      creditBack();
      sendAllBeats(t);
      if (n == 2) begin
        beat(t ^ 3'd5, 2'd0, '1);
        check(tagErr == 1, "R9 stray write flagged", 256'(tagErr), 256'(1));
      end
      check(jobRunning == 0, "R7 not running before response", 256'(jobRunning), 256'(0));
      rsp(t, 8'd0);
      check(jobRunning == 1, "R7 running after clean response", 256'(jobRunning), 256'(1));
      checkDesc("R6 beat placement");
      jobReq(2'd2, a ^ 64'h80);
      noCmd(4, "R3 start while running");
      check(jobRunning == 1, "R3 still running", 256'(jobRunning), 256'(1));
      if (n == 3) begin
        rsp(t, 8'd0);
        check(tagErr == 1, "R9 stray response flagged", 256'(tagErr), 256'(1));
        check(jobRunning == 1, "R9 state unchanged", 256'(jobRunning), 256'(1));
        checkDesc("R9 data unchanged");
      end
      jobReq(2'd1, 0);
      check(jobReady == 1 && jobRunning == 0, "R10 reset from running", 256'(jobReady), 256'(1));
    end

    // error completion code
    jobReq(2'd2, 64'h2000);
    expectCmd(64'h2000, t); creditBack();
    sendAllBeats(t);
    rsp(t, 8'd5);
    check(jobFail == 1 && jobReady == 1, "R8 fail on error code", 256'({jobFail, jobReady}), 256'(3));
    @(negedge clk);
    check(jobFail == 0 && jobRunning == 0, "R8 fail is a pulse", 256'(jobFail), 256'(0));

    // response before all beats
    jobReq(2'd2, 64'h3000);
    expectCmd(64'h3000, t); creditBack();
    beat(t, 2'd1, 256'h11); beat(t, 2'd3, 256'h33);
    rsp(t, 8'd0);
    check(jobFail == 1 && jobRunning == 0, "R8 fail on missing beats", 256'({jobFail, jobRunning}), 256'(2));

    // abandon mid-fetch, tag stays reserved
    jobReq(2'd2, 64'h4000);
    expectCmd(64'h4000, t0); creditBack();
    jobReq(2'd1, 0);
    check(jobReady == 1, "R10 reset mid-fetch", 256'(jobReady), 256'(1));
    jobReq(2'd2, 64'h5000);
    expectCmd(64'h5000, t); creditBack();
    check(t != t0, "R4 abandoned tag not reused", 256'(t), 256'(t0 + 1));
    sendAllBeats(t);
    rsp(t, 8'd0);
    check(jobRunning == 1, "R7 run after abandon", 256'(jobRunning), 256'(1));
    rsp(t0, 8'd0);
    check(tagErr == 0 && jobRunning == 1, "R10 late response accepted", 256'(tagErr), 256'(0));
    jobReq(2'd1, 0);

    // credit exhaustion
    for (int i = 0; i < CREDITS; i++) begin
      jobReq(2'd2, 64'h6000 + 64'(i * 128));
      expectCmd(64'h6000 + 64'(i * 128), t);
      rsp(t, 8'd1);
    end
    check(mCredit == 0, "R5 model credits spent", 256'(mCredit), 256'(0));
    jobReq(2'd2, 64'h7000);
    noCmd(8, "R5 no command at zero credit");
    creditBack();
    expectCmd(64'h7000, t);
    check(1'b1, "R5 command after credit return", 0, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule